// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the control unit of an 8-bit processor core. It keeps a pending latch for each maskable source and one for the non-maskable source. When the core reports that an instruction has finished, the block decides whether a request may be taken. If one is taken, it runs a fixed eight-clock entry routine. The routine pushes the return address and the status byte onto a stack that grows downward in a fixed page. It then fetches a 16-bit handler address from the vector pair of the chosen source and loads that address into the program counter.

The block also runs the matching return routine. That routine pops the status byte and both halves of the program counter, and it raises the stack pointer again. The core owns the program counter and the status byte. The block reads them on `pc_i` and `psw_i` and writes them through load strobes. The block owns the stack pointer. While `busy_o` is high, the core must stall and leave the bus to the block. Only the program counter and the status byte are saved automatically. All other core registers are left to software.

Top module: `irq_seq`

## Requirements
- R1: A request pulse on `req_i[k]` sets pending latch k. The latch stays set until its source is accepted, until `clr_i[k]` is pulsed, or until reset. If a clear and a request arrive in the same cycle, the clear wins.
- R2: A request is accepted only at a clock edge where `boundary_i` is high and the block is idle. After that edge, `busy_o` stays high for exactly 8 cycles, and `pc_we_o` is high in the last of them.
- R3: A maskable source can be accepted only while bit IBIT of `psw_i` (the enable flag, bit 2 by default) is 1 and its own bit in `ien_i` is 1. While the flag is 0, no maskable source is taken, whatever its priority.
- R4: The entry bus order is fixed. Cycle 2 writes PC[15:8] to {STK_PAGE, SP}. Cycle 3 writes PC[7:0] to SP-1. Cycle 4 writes the status byte to SP-2. Cycle 5 reads the low vector byte and cycle 6 reads the high vector byte. Reads and writes never happen in the same cycle, and SP ends 3 lower than it started.
- R5: Source k takes its vector low byte from VEC_BASE+2k and its high byte from the next address (source 3 uses 0xFFE6/0xFFE7 by default). The non-maskable source uses NMI_VEC and NMI_VEC+1. The PC is loaded with {high, low}.
- R6: When a maskable source is accepted, cycle 1 writes the status byte back with bit IBIT cleared and all other bits kept. The status byte pushed in cycle 4 is the value it had before acceptance.
- R7: The latch of the accepted source is cleared during entry. The latches of all other sources keep their state.
- R8: When several sources are pending and enabled, the lowest index wins.
- R9: A pending non-maskable request is accepted even when the enable flag is 0. While it is being serviced, no request of any kind is accepted, even with the flag set. The block is lifted when the return routine completes.
- R10: A pulse on `reti_i` while idle runs a 5-cycle return. It reads the status byte, PC[7:0] and PC[15:8] from SP+1, SP+2 and SP+3, raises SP by 3, and loads the PC and the status byte in its fifth cycle.
- R11: After reset, SP equals SP_INIT, all latches are clear, `busy_o` is low, and no bus cycle is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | Maskable request pulses, one per source |
| clr_i | input | NSRC | Software clear pulses for the pending latches |
| ien_i | input | NSRC | Individual source enables |
| nmi_i | input | 1 | Non-maskable request pulse |
| boundary_i | input | 1 | Current instruction has completed |
| reti_i | input | 1 | Start of the return-from-interrupt instruction |
| pc_i | input | 16 | Core program counter (return address) |
| psw_i | input | 8 | Core status byte |
| bus_rdata_i | input | 8 | Read data, valid one cycle after the read strobe |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_wr_o | output | 1 | Bus write strobe |
| pc_o | output | 16 | Value to load into the program counter |
| pc_we_o | output | 1 | Program counter load strobe |
| psw_o | output | 8 | Value to load into the status byte |
| psw_we_o | output | 1 | Status byte load strobe |
| sp_o | output | 8 | Stack pointer |
| busy_o | output | 1 | Entry or return routine in progress |

## Verification
The bench builds the block with its defaults: four sources, enable flag at bit 2, vectors based at 0xFFE0, the non-maskable vector at 0xFFFA, and the stack at page 0x01 starting from 0xFF. With these values source 3 lands on the 0xFFE6 pair. A push from 0xFF can be checked byte by byte at fixed addresses. A small set of sources is enough to reach every priority and enable combination, two-level nesting and the non-maskable block, each within a few hundred cycles.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ENTRY  = 2'd1,
    ST_RETURN = 2'd2
  } seq_st_t;
endpackage

// File: rtl/irq_req_bank.sv
// Pending latches for maskable and non-maskable sources plus a fixed
// priority pick (lowest index wins).
module irq_req_bank #(
  parameter int NSRC = 4,
  parameter int IW   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] ien_i,
  input  logic            ack_valid_i,
  input  logic [IW-1:0]   ack_idx_i,
  input  logic            nmi_i,
  input  logic            nmi_ack_i,
  output logic            any_en_o,
  output logic [IW-1:0]   win_idx_o,
  output logic            nmi_pend_o
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] ack_mask;

  for (genvar g = 0; g < NSRC; g++) begin : g_ack
    assign ack_mask[g] = ack_valid_i && (ack_idx_i == IW'(g));
  end

  // Clear (software or acceptance) dominates a same-cycle request.
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend | req_i) & ~clr_i & ~ack_mask;
  end

  always_ff @(posedge clk) begin
    if (rst)            nmi_pend_o <= 1'b0;
    else if (nmi_i)     nmi_pend_o <= 1'b1;
    else if (nmi_ack_i) nmi_pend_o <= 1'b0;
  end

  always_comb begin
    win_idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i] && ien_i[i]) win_idx_o = IW'(i);
    end
    any_en_o = |(pend & ien_i);
  end
endmodule

// File: rtl/irq_seq_fsm.sv
// Entry (8 cycles) and return (5 cycles) routines, stack pointer,
// non-maskable block.
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int          IW       = 2,
  parameter int          IBIT     = 2,
  parameter logic [15:0] VEC_BASE = 16'hFFE0,
  parameter logic [15:0] NMI_VEC  = 16'hFFFA,
  parameter logic [7:0]  STK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary_i,
  input  logic          reti_i,
  input  logic [15:0]   pc_i,
  input  logic [7:0]    psw_i,
  input  logic [7:0]    bus_rdata_i,
  input  logic          any_en_i,
  input  logic [IW-1:0] win_idx_i,
  input  logic          nmi_pend_i,
  output seq_st_t       st_o,
  output logic          nmi_blk_o,
  output logic          ack_valid_o,
  output logic [IW-1:0] ack_idx_o,
  output logic          nmi_ack_o,
  output logic [15:0]   bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [15:0]   pc_o,
  output logic          pc_we_o,
  output logic [7:0]    psw_o,
  output logic          psw_we_o,
  output logic [7:0]    sp_o
);
  localparam logic [7:0] IMASK = 8'(1 << IBIT);

  logic [2:0]    step;
  logic [15:0]   pc_sav;
  logic [7:0]    psw_sav, psw_pop, lo_q, hi_q;
  logic          is_nmi;
  logic [IW-1:0] src;
  logic          go_ret, go_nmi, go_irq;
  logic [15:0]   vec_a;

  assign go_ret = (st_o == ST_IDLE) && reti_i;
  assign go_nmi = (st_o == ST_IDLE) && !reti_i && boundary_i && nmi_pend_i && !nmi_blk_o;
  assign go_irq = (st_o == ST_IDLE) && !reti_i && boundary_i && !go_nmi && !nmi_blk_o
                  && psw_i[IBIT] && any_en_i;
  assign vec_a  = is_nmi ? NMI_VEC : VEC_BASE + 16'({src, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      st_o <= ST_IDLE; step <= '0; sp_o <= SP_INIT; nmi_blk_o <= 1'b0;
      pc_sav <= '0; psw_sav <= '0; psw_pop <= '0; lo_q <= '0; hi_q <= '0;
      is_nmi <= 1'b0; src <= '0;
    end else begin
      case (st_o)
        ST_IDLE: begin
          step <= '0;
          if (go_ret) begin
            st_o <= ST_RETURN;
          end else if (go_nmi || go_irq) begin
            st_o    <= ST_ENTRY;
            pc_sav  <= pc_i;
            psw_sav <= psw_i;
            is_nmi  <= go_nmi;
            src     <= win_idx_i;
            if (go_nmi) nmi_blk_o <= 1'b1;
          end
        end
        ST_ENTRY: begin
          step <= step + 3'd1;
          if (step >= 3'd1 && step <= 3'd3) sp_o <= sp_o - 8'd1;
          if (step == 3'd5) lo_q <= bus_rdata_i;
          if (step == 3'd6) hi_q <= bus_rdata_i;
          if (step == 3'd7) st_o <= ST_IDLE;
        end
        ST_RETURN: begin
          step <= step + 3'd1;
          if (step <= 3'd2) sp_o <= sp_o + 8'd1;
          if (step == 3'd1) psw_pop <= bus_rdata_i;
          if (step == 3'd2) lo_q <= bus_rdata_i;
          if (step == 3'd3) hi_q <= bus_rdata_i;
          if (step == 3'd4) begin
            st_o      <= ST_IDLE;
            nmi_blk_o <= 1'b0;
          end
        end
        default: st_o <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ack_valid_o = 1'b0; ack_idx_o = src; nmi_ack_o = 1'b0;
    bus_addr_o = '0; bus_wdata_o = '0; bus_rd_o = 1'b0; bus_wr_o = 1'b0;
    pc_o = {hi_q, lo_q}; pc_we_o = 1'b0;
    psw_o = psw_sav & ~IMASK; psw_we_o = 1'b0;
    if (st_o == ST_ENTRY) begin
      case (step)
        3'd0: begin
          ack_valid_o = !is_nmi;
          nmi_ack_o   = is_nmi;
          psw_we_o    = !is_nmi;
        end
        3'd1: begin bus_wr_o = 1'b1; bus_addr_o = {STK_PAGE, sp_o}; bus_wdata_o = pc_sav[15:8]; end
        3'd2: begin bus_wr_o = 1'b1; bus_addr_o = {STK_PAGE, sp_o}; bus_wdata_o = pc_sav[7:0]; end
        3'd3: begin bus_wr_o = 1'b1; bus_addr_o = {STK_PAGE, sp_o}; bus_wdata_o = psw_sav; end
        3'd4: begin bus_rd_o = 1'b1; bus_addr_o = vec_a; end
        3'd5: begin bus_rd_o = 1'b1; bus_addr_o = vec_a + 16'd1; end
        3'd7: pc_we_o = 1'b1;
        default: ;
      endcase
    end else if (st_o == ST_RETURN) begin
      if (step <= 3'd2) begin
        bus_rd_o   = 1'b1;
        bus_addr_o = {STK_PAGE, sp_o + 8'd1};
      end
      if (step == 3'd4) begin
        pc_we_o  = 1'b1;
        psw_we_o = 1'b1;
        psw_o    = psw_pop;
      end
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int          NSRC     = 4,
  parameter int          IBIT     = 2,
  parameter logic [15:0] VEC_BASE = 16'hFFE0,
  parameter logic [15:0] NMI_VEC  = 16'hFFFA,
  parameter logic [7:0]  STK_PAGE = 8'h01,
  parameter logic [7:0]  SP_INIT  = 8'hFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  input  logic [NSRC-1:0] ien_i,
  input  logic            nmi_i,
  input  logic            boundary_i,
  input  logic            reti_i,
  input  logic [15:0]     pc_i,
  input  logic [7:0]      psw_i,
  input  logic [7:0]      bus_rdata_i,
  output logic [15:0]     bus_addr_o,
  output logic [7:0]      bus_wdata_o,
  output logic            bus_rd_o,
  output logic            bus_wr_o,
  output logic [15:0]     pc_o,
  output logic            pc_we_o,
  output logic [7:0]      psw_o,
  output logic            psw_we_o,
  output logic [7:0]      sp_o,
  output logic            busy_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  seq_st_t       st;
  logic          nmi_blk, nmi_pend, any_en, ack_valid, nmi_ack;
  logic [IW-1:0] win_idx, ack_idx;

  irq_req_bank #(.NSRC(NSRC), .IW(IW)) u_bank (
    .clk(clk), .rst(rst), .req_i(req_i), .clr_i(clr_i), .ien_i(ien_i),
    .ack_valid_i(ack_valid), .ack_idx_i(ack_idx), .nmi_i(nmi_i),
    .nmi_ack_i(nmi_ack), .any_en_o(any_en), .win_idx_o(win_idx),
    .nmi_pend_o(nmi_pend)
  );

  irq_seq_fsm #(
    .IW(IW), .IBIT(IBIT), .VEC_BASE(VEC_BASE), .NMI_VEC(NMI_VEC),
    .STK_PAGE(STK_PAGE), .SP_INIT(SP_INIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .reti_i(reti_i),
    .pc_i(pc_i), .psw_i(psw_i), .bus_rdata_i(bus_rdata_i),
    .any_en_i(any_en), .win_idx_i(win_idx), .nmi_pend_i(nmi_pend),
    .st_o(st), .nmi_blk_o(nmi_blk), .ack_valid_o(ack_valid),
    .ack_idx_o(ack_idx), .nmi_ack_o(nmi_ack), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o),
    .pc_o(pc_o), .pc_we_o(pc_we_o), .psw_o(psw_o), .psw_we_o(psw_we_o),
    .sp_o(sp_o)
  );

  assign busy_o = (st != ST_IDLE);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int IBIT = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       boundary_i,
  input logic       reti_i,
  input logic [7:0] psw_i,
  input logic       bus_rd_o,
  input logic       bus_wr_o,
  input logic [7:0] sp_o,
  input logic       pc_we_o,
  input seq_st_t    st,
  input logic       nmi_blk,
  input logic       nmi_pend
);
  a_r4_rw_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd_o && bus_wr_o));

  a_r4_push_dec: assert property (@(posedge clk) disable iff (rst)
    bus_wr_o |=> sp_o == $past(sp_o) - 8'd1);

  a_r10_pop_inc: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RETURN && bus_rd_o) |=> sp_o == $past(sp_o) + 8'd1);

  a_r2_entry_len: assert property (@(posedge clk) disable iff (rst)
    (pc_we_o && st == ST_ENTRY) |-> ($past(st, 7) == ST_ENTRY && $past(st, 8) == ST_IDLE));

  a_r3_flag_gate: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && boundary_i && !reti_i && !psw_i[IBIT] && !nmi_pend) |=> st != ST_ENTRY);

  a_r9_nmi_block: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && nmi_blk && !reti_i) |=> st != ST_ENTRY);
endmodule

bind irq_seq irq_seq_chk #(.IBIT(IBIT)) u_chk (.*);

// File: tb/test_irq_seq.sv
module test_irq_seq;
  localparam logic [15:0] PC_RST = 16'h1234;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] req = '0, clr = '0, ien = '0;
  logic nmi = 1'b0, boundary = 1'b0, reti = 1'b0;
  logic [15:0] cpc;
  logic [7:0]  cpsw, rdata;
  logic [15:0] bus_addr, pc_o;
  logic [7:0]  bus_wdata, psw_o, sp;
  logic bus_rd, bus_wr, pc_we, psw_we, busy;
  logic [7:0] psw_rst_val = 8'hA5;
  logic psw_set = 1'b0;
  logic [7:0] psw_set_val = '0;

  int checks = 0, errors = 0;
  int nbusy, nwr, nrd;
  logic [15:0] waddr [0:3];
  logic [7:0]  wdat  [0:3];
  logic [15:0] raddr [0:3];
  logic [7:0]  stk   [0:255];
  bit timeout = 0;

  always #4 clk = ~clk;

  irq_seq i_irq_seq (
    .clk(clk), .rst(rst), .req_i(req), .clr_i(clr), .ien_i(ien), .nmi_i(nmi),
    .boundary_i(boundary), .reti_i(reti), .pc_i(cpc), .psw_i(cpsw),
    .bus_rdata_i(rdata), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .pc_o(pc_o), .pc_we_o(pc_we),
    .psw_o(psw_o), .psw_we_o(psw_we), .sp_o(sp), .busy_o(busy)
  );

  function automatic logic [15:0] exp_vec(int s);
    return {8'(8'hA0 + s), 8'(8'h10 + 3 * s)};
  endfunction

  function automatic logic [7:0] vbyte(logic [15:0] a);
    logic [15:0] v;
    if (a == 16'hFFFA) return 8'h5A;
    if (a == 16'hFFFB) return 8'hC3;
    if (a >= 16'hFFE0 && a <= 16'hFFE7) begin
      v = exp_vec(int'((a - 16'hFFE0) >> 1));
      return a[0] ? v[15:8] : v[7:0];
    end
    return 8'h00;
  endfunction

  // core and memory model
  always @(posedge clk) begin
    if (rst) begin
      cpc <= PC_RST; cpsw <= psw_rst_val;
    end else begin
      if (pc_we) cpc <= pc_o;
      if (psw_we) cpsw <= psw_o;
      else if (psw_set) cpsw <= psw_set_val;
    end
    if (bus_wr && bus_addr[15:8] == 8'h01) stk[bus_addr[7:0]] <= bus_wdata;
    rdata <= !bus_rd ? 8'h00 : (bus_addr[15:8] == 8'h01) ? stk[bus_addr[7:0]] : vbyte(bus_addr);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [7:0] p);
    psw_rst_val = p; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic observe;
    nbusy = 0; nwr = 0; nrd = 0;
    while (busy && nbusy < 32) begin
      if (bus_wr && nwr < 4) begin waddr[nwr] = bus_addr; wdat[nwr] = bus_wdata; nwr++; end
      if (bus_rd && nrd < 4) begin raddr[nrd] = bus_addr; nrd++; end
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic fire_boundary;
    boundary = 1'b1; @(negedge clk); boundary = 1'b0; observe();
  endtask

  task automatic fire_reti;
    reti = 1'b1; @(negedge clk); reti = 1'b0; observe();
  endtask

  task automatic pulse_req(logic [3:0] m);
    req = m; @(negedge clk); req = '0;
  endtask

  task automatic set_psw(logic [7:0] v);
    psw_set_val = v; psw_set = 1'b1; @(negedge clk); psw_set = 1'b0;
  endtask

  // {req[3:0], ien[3:0], flag, accept, src[1:0]}
  localparam int NV = 8;
  localparam logic [11:0] VT [0:NV-1] = '{
    {4'b0001, 4'b1111, 1'b1, 1'b1, 2'd0},
    {4'b1000, 4'b1111, 1'b1, 1'b1, 2'd3},
    {4'b0110, 4'b1111, 1'b1, 1'b1, 2'd1},
    {4'b0110, 4'b1101, 1'b1, 1'b1, 2'd2},
    {4'b1111, 4'b0000, 1'b1, 1'b0, 2'd0},
    {4'b0100, 4'b1111, 1'b0, 1'b0, 2'd0},
    {4'b1010, 4'b1010, 1'b1, 1'b1, 2'd1},
    {4'b0000, 4'b1111, 1'b1, 1'b0, 2'd0}
  };

  task automatic run_all;
    // R11 reset state
    do_reset(8'hA5);
    chk("R11 sp", sp, 8'hFF);
    chk("R11 busy", busy, 0);
    chk("R11 bus", {bus_rd, bus_wr}, 0);

    // table walk: R3 R5 R8 R2
    for (int i = 0; i < NV; i++) begin
      do_reset(VT[i][3] ? 8'hA5 : 8'hA1);
      ien = VT[i][7:4];
      pulse_req(VT[i][11:8]);
      fire_boundary();
      if (VT[i][2]) begin
        chk("R5/R8 pc", cpc, exp_vec(int'(VT[i][1:0])));
        chk("R2 len", nbusy, 8);
        chk("R4 sp", sp, 8'hFC);
      end else begin
        chk("R3 no accept", nbusy, 0);
        chk("R3 pc kept", cpc, PC_RST);
      end
    end

    // R4 R6 bus order and status update, source 3 at FFE6
    do_reset(8'hA5); ien = 4'hF;
    pulse_req(4'b1000);
    fire_boundary();
    chk("R4 nwr", nwr, 3);
    chk("R4 w0", {waddr[0], wdat[0]}, {16'h01FF, 8'h12});
    chk("R4 w1", {waddr[1], wdat[1]}, {16'h01FE, 8'h34});
    chk("R6 pushed psw", {waddr[2], wdat[2]}, {16'h01FD, 8'hA5});
    chk("R5 rd lo", raddr[0], 16'hFFE6);
    chk("R5 rd hi", raddr[1], 16'hFFE7);
    chk("R6 flag cleared", cpsw, 8'hA1);

    // R7 R10: accept src1, return, then src2 still pending
    do_reset(8'hA5); ien = 4'hF;
    pulse_req(4'b0110);
    fire_boundary();
    chk("R7 first", cpc, exp_vec(1));
    fire_reti();
    chk("R10 len", nbusy, 5);
    chk("R10 pc", cpc, PC_RST);
    chk("R10 psw", cpsw, 8'hA5);
    chk("R10 sp", sp, 8'hFF);
    fire_boundary();
    chk("R7 other kept", cpc, exp_vec(2));
    fire_reti();
    fire_boundary();
    chk("R7 accepted cleared", nbusy, 0);

    // R1 hold with flag 0, then clear paths
    do_reset(8'hA1); ien = 4'hF;
    pulse_req(4'b0001);
    fire_boundary();
    fire_boundary();
    chk("R1 held blocked", nbusy, 0);
    set_psw(8'hA5);
    fire_boundary();
    chk("R1 held accepted", cpc, exp_vec(0));
    do_reset(8'hA5); ien = 4'hF;
    pulse_req(4'b0001);
    clr = 4'b0001; @(negedge clk); clr = '0;
    fire_boundary();
    chk("R1 clear", nbusy, 0);
    req = 4'b0010; clr = 4'b0010; @(negedge clk); req = '0; clr = '0;
    fire_boundary();
    chk("R1 clear wins", nbusy, 0);

    // R3 nesting: higher priority waits for the flag
    do_reset(8'hA5); ien = 4'hF;
    pulse_req(4'b1000);
    fire_boundary();
    pulse_req(4'b0001);
    fire_boundary();
    chk("R3 nested blocked", nbusy, 0);
    set_psw(8'hA5);
    fire_boundary();
    chk("R3 nested pc", cpc, exp_vec(0));
    chk("R3 nested sp", sp, 8'hF9);
    fire_reti();
    chk("R10 nested pc", cpc, exp_vec(3));
    chk("R10 nested sp", sp, 8'hFC);

    // R9 non-maskable
    do_reset(8'hA1); ien = 4'hF;
    nmi = 1'b1; @(negedge clk); nmi = 1'b0;
    fire_boundary();
    chk("R9 nmi pc", cpc, 16'hC35A);
    chk("R9 nmi psw untouched", cpsw, 8'hA1);
    set_psw(8'hA5);
    pulse_req(4'b0001);
    fire_boundary();
    chk("R9 blocked", nbusy, 0);
    fire_reti();
    chk("R9 ret pc", cpc, PC_RST);
    chk("R9 ret psw", cpsw, 8'hA1);
    set_psw(8'hA5);
    fire_boundary();
    chk("R9 lifted", cpc, exp_vec(0));
  endtask

  initial begin
    fork
      run_all();
      begin repeat (50000) @(posedge clk); timeout = 1; end
    join_any
    disable fork;
    if (timeout) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule